// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a byte-wide serial memory on a two-wire bus. A fast system clock oversamples SCL and SDA, which arrive already synchronised. The block finds start and stop conditions on the bus and compares the device select byte against three strap inputs. A write then takes a two-byte word address and collects data bytes into a page buffer. A read instead streams bytes out of an internal array whose size is a parameter. The block never drives SDA high. It only enables a pull-down.

At the stop condition that ends a write carrying data, the buffered page is committed to the array. A busy timer then models the internal programming time. While the timer runs, the block ignores its own device select byte. A write-protect input suppresses every commit. A random read is a write of the address alone, followed by a repeated start and a read select.

Top module: `tw_eeprom_slave`

## Requirements
- R1: After reset the block does not pull SDA low, and it stays released until a start condition is followed by a matching select byte.
- R2: A select byte is acknowledged only when bits 7:4 are 1010 and bits 3:1 equal `sel_i`. Bit 0 chooses the direction, where 1 means read.
- R3: Each address and write-data byte received after a matching select is acknowledged by holding SDA low through the ninth SCL pulse.
- R4: Bytes written with a 16-bit word address (high byte first) read back unchanged from the same addresses, and the array changes only during the write cycle after the stop.
- R5: During the WR_TICKS clock cycles that follow a stop ending a write with data, a select byte is not acknowledged. Once that time has passed, it is acknowledged again.
- R6: During a write, only the low 7 address bits advance after each data byte. They wrap inside the current 128-byte page, and the next page is left untouched.
- R7: During a read, the full address advances after each byte and wraps from the last array location back to location 0.
- R8: While `wp_i` is high at the stop, the array is not changed and no write cycle starts.
- R9: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next start.
- R10: Bus traffic is ignored until a start condition. A write that is interrupted by a repeated start, with no stop, stores nothing and starts no write cycle.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sel_i | input | 3 | Hardwired select straps |
| wp_i | input | 1 | 1 blocks all array writes |

## Verification
A bit counter that is out of step shows up within one byte as an acknowledge on the wrong clock pulse, or as read data shifted by one bit. A wrong address register shows up as wrong read-back data on the first byte read after a write. A page pointer that does not wrap shows up as a changed byte in the neighbouring page. A busy timer with the wrong length shows up as an acknowledge to a select sent right after the stop, or as no acknowledge once the write time has passed.

// File: rtl/twe_pkg.sv
package twe_pkg;

    localparam int         WADDR_W  = 16;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } xfer_st_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } line_ev_t;

    function automatic logic sel_match(input logic [7:0] b, input logic [2:0] sel);
        return (b[7:4] == DEV_TYPE) && (b[3:1] == sel);
    endfunction

endpackage

// File: rtl/twe_line_events.sv
module twe_line_events
    import twe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.scl_rise = scl_i & ~scl_q;
        ev.scl_fall = ~scl_i & scl_q;
        ev.start    = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop     = scl_i & scl_q & ~sda_q & sda_i;
        ev.sda      = sda_i;
    end

endmodule

// File: rtl/twe_busy_timer.sv
module twe_busy_timer #(
    parameter int TICKS = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);

    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (go) begin
            remain <= CW'(TICKS);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

    // R5: a new write cycle is only requested once the previous one is over
    a_r5_go_when_idle: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);

endmodule

// File: rtl/twe_page_buf.sv
module twe_page_buf #(
    parameter int PAGE = 128,
    parameter int MA_W = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 wr,
    input  logic [$clog2(PAGE)-1:0] idx,
    input  logic [7:0]           din,
    input  logic                 go,
    input  logic [MA_W-$clog2(PAGE)-1:0] base,
    output logic                 mem_we,
    output logic [MA_W-1:0]      mem_addr,
    output logic [7:0]           mem_din,
    output logic                 active
);

    localparam int PG_W = $clog2(PAGE);
    localparam int BS_W = MA_W - PG_W;

    logic [7:0]      data [PAGE];
    logic [PAGE-1:0] vld;
    logic [PG_W-1:0] ptr;
    logic [BS_W-1:0] base_q;
    logic            run;

    always_ff @(posedge clk) begin
        if (wr) data[idx] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= '0;
            ptr    <= '0;
            base_q <= '0;
            run    <= 1'b0;
        end else begin
            if (clr)     vld      <= '0;
            else if (wr) vld[idx] <= 1'b1;

            if (go) begin
                run    <= 1'b1;
                ptr    <= '0;
                base_q <= base;
            end else if (run) begin
                ptr <= ptr + 1'b1;
                if (ptr == PG_W'(PAGE - 1)) run <= 1'b0;
            end
        end
    end

    assign mem_we   = run && vld[ptr];
    assign mem_addr = {base_q, ptr};
    assign mem_din  = data[ptr];
    assign active   = run;

    // R6: the buffer is not filled while it is being committed
    a_r6_no_fill_in_commit: assert property (@(posedge clk) disable iff (rst)
        run |-> !wr);

endmodule

// File: rtl/twe_mem_array.sv
module twe_mem_array #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
    import twe_pkg::*;
#(
    parameter int MEM_BYTES  = 2048,
    parameter int PAGE_BYTES = 128,
    parameter int WR_TICKS   = 250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] sel_i,
    input  logic       wp_i
);

    localparam int MA_W = $clog2(MEM_BYTES);
    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam int BS_W = MA_W - PG_W;

    line_ev_t   ev;
    xfer_st_e   st, st_nxt;
    logic [3:0] cnt;
    logic [7:0] sh;
    logic [7:0] hi_q;
    logic [MA_W-1:0] addr;
    logic       ackd;
    logic       mnack;
    logic       got_data;
    logic       byte_ack;
    logic       busy;
    logic       commit_go;
    logic       fill_wr;
    logic       fill_clr;
    logic       mem_we;
    logic [MA_W-1:0] mem_waddr;
    logic [7:0] mem_wdata;
    logic [7:0] rd_byte;
    logic       commit_active;
    logic [WADDR_W-1:0] wa_full;

    twe_line_events u_ev (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    twe_busy_timer #(.TICKS(WR_TICKS)) u_busy (
        .clk  (clk),
        .rst  (rst),
        .go   (commit_go),
        .busy (busy)
    );

    twe_page_buf #(.PAGE(PAGE_BYTES), .MA_W(MA_W)) u_pbuf (
        .clk      (clk),
        .rst      (rst),
        .clr      (fill_clr),
        .wr       (fill_wr),
        .idx      (addr[PG_W-1:0]),
        .din      (sh),
        .go       (commit_go),
        .base     (addr[MA_W-1:PG_W]),
        .mem_we   (mem_we),
        .mem_addr (mem_waddr),
        .mem_din  (mem_wdata),
        .active   (commit_active)
    );

    twe_mem_array #(.DEPTH(MEM_BYTES), .AW(MA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (addr),
        .rdata (rd_byte)
    );

    // decision taken on the falling SCL edge that ends the eighth bit
    always_comb begin
        byte_ack = 1'b1;
        st_nxt   = st;
        case (st)
            ST_DEV: begin
                byte_ack = sel_match(sh, sel_i) && !busy;
                st_nxt   = sh[0] ? ST_RDAT : ST_AHI;
            end
            ST_AHI:  st_nxt = ST_ALO;
            ST_ALO:  st_nxt = ST_WDAT;
            default: st_nxt = st;
        endcase
    end

    assign wa_full   = {hi_q, sh};
    assign fill_wr   = ev.scl_fall && (st == ST_WDAT) && (cnt == 4'd8);
    assign fill_clr  = ev.scl_fall && (st == ST_ALO)  && (cnt == 4'd8);
    assign commit_go = ev.stop && got_data && !wp_i && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            hi_q     <= '0;
            addr     <= '0;
            ackd     <= 1'b0;
            mnack    <= 1'b0;
            got_data <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (ev.stop) begin
            st       <= ST_IDLE;
            sda_oe   <= 1'b0;
            got_data <= 1'b0;
        end else if (ev.start) begin
            st       <= ST_DEV;
            cnt      <= '0;
            sda_oe   <= 1'b0;
            got_data <= 1'b0;
        end else if (st != ST_IDLE) begin
            if (ev.scl_rise) begin
                if (cnt < 4'd8) begin
                    if (st != ST_RDAT) sh <= {sh[6:0], ev.sda};
                    cnt <= cnt + 1'b1;
                end else if (cnt == 4'd8) begin
                    // ninth pulse: in a read this is the master's answer;
                    // after a select it is our own low acknowledge
                    mnack <= ev.sda;
                    cnt   <= 4'd9;
                end
            end else if (ev.scl_fall) begin
                if (st == ST_RDAT && cnt >= 4'd1 && cnt <= 4'd7) begin
                    sda_oe <= ~sh[6];
                    sh     <= {sh[6:0], 1'b0};
                end else if (cnt == 4'd8) begin
                    if (st == ST_RDAT) begin
                        sda_oe <= 1'b0;
                        addr   <= addr + 1'b1;
                    end else begin
                        sda_oe <= byte_ack;
                        ackd   <= byte_ack;
                        if (byte_ack) st <= st_nxt;
                        case (st)
                            ST_AHI: hi_q <= sh;
                            ST_ALO: addr <= MA_W'(wa_full);
                            ST_WDAT: begin
                                addr     <= {addr[MA_W-1:PG_W], addr[PG_W-1:0] + 1'b1};
                                got_data <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end else if (cnt == 4'd9) begin
                    cnt <= '0;
                    if (!ackd) begin
                        st     <= ST_IDLE;
                        sda_oe <= 1'b0;
                    end else if (st == ST_RDAT) begin
                        if (mnack) begin
                            st     <= ST_IDLE;
                            sda_oe <= 1'b0;
                        end else begin
                            sda_oe <= ~rd_byte[7];
                            sh     <= rd_byte;
                        end
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end
            end
        end
    end

    // R11: the data line is only touched while the clock is low
    a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_i));

    // R5: no acknowledge of the select byte while the write cycle runs
    a_r5_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) && $past(st) == ST_DEV) |-> !$past(busy));

    // R8: a write cycle never starts with write protect raised
    a_r8_wp_no_cycle: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(wp_i));

    // R4: the array is written only inside the write cycle
    a_r4_we_in_cycle: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (busy && commit_active));

    // R9: an idle block never holds the line
    a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

endmodule

// File: tb/test_tw_eeprom_slave.sv
module test_tw_eeprom_slave;

    localparam int         WRT  = 3000;
    localparam int         Q    = 5;
    localparam logic [2:0] SEL  = 3'b101;
    localparam logic [7:0] DEVW = {4'b1010, SEL, 1'b0};
    localparam logic [7:0] DEVR = {4'b1010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int tests = 0;
    int fails = 0;
    int scl_high_changes = 0;
    logic oe_seen = 1'b0;
    logic oe_prev = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    tw_eeprom_slave #(.MEM_BYTES(2048), .PAGE_BYTES(128), .WR_TICKS(WRT)) i_tw_eeprom_slave (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (m_scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .sel_i  (SEL),
        .wp_i   (wp)
    );

    always @(posedge clk) begin
        #1;
        if (!rst && sda_oe !== oe_prev && m_scl) scl_high_changes++;
        if (sda_oe) oe_seen = 1'b1;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start;
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic do_stop;
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2 * Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(Q);
        s = sda_bus;  tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            b = {b[6:0], s};
        end
        clk_bit(~give_ack, s);
        m_sda = 1'b1;
    endtask

    task automatic set_addr(input logic [15:0] a, output logic ok);
        logic k0, k1, k2;
        do_start;
        send_byte(DEVW, k0);
        send_byte(a[15:8], k1);
        send_byte(a[7:0], k2);
        ok = k0 & k1 & k2;
    endtask

    task automatic write_burst(input logic [15:0] a, input logic [31:0] d,
                               input int n, output logic ok);
        logic k;
        set_addr(a, ok);
        for (int i = 0; i < n; i++) begin
            send_byte(d[31 - 8 * i -: 8], k);
            ok = ok & k;
        end
        do_stop;
    endtask

    task automatic read_burst(input logic [15:0] a, input int n, output logic [31:0] q);
        logic ok, k;
        logic [7:0] b;
        q = '0;
        set_addr(a, ok);
        do_start;
        send_byte(DEVR, k);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            q[31 - 8 * i -: 8] = b;
        end
        do_stop;
    endtask

    task automatic wait_cycle;
        tick(WRT + 100);
    endtask

    task automatic t_reset;
        chk("R1 sda released after reset", {31'd0, sda_oe}, 32'd0);
    endtask

    task automatic t_select;
        logic k;
        do_start; send_byte(DEVW, k); do_stop;
        chk("R2 matching select acked", {31'd0, k}, 32'd1);
        do_start; send_byte({4'b1010, ~SEL, 1'b0}, k);
        chk("R2 wrong straps not acked", {31'd0, k}, 32'd0);
        send_byte(DEVW, k);
        chk("R10 byte without start ignored", {31'd0, k}, 32'd0);
        do_stop;
        do_start; send_byte({4'b1011, SEL, 1'b0}, k); do_stop;
        chk("R2 wrong type nibble not acked", {31'd0, k}, 32'd0);
    endtask

    task automatic t_write_read;
        logic ok, k;
        logic [31:0] q;
        write_burst(16'h0110, 32'h112233_00, 3, ok);
        chk("R3 address and data bytes acked", {31'd0, ok}, 32'd1);
        do_start; send_byte(DEVW, k); do_stop;
        chk("R5 select refused during write cycle", {31'd0, k}, 32'd0);
        wait_cycle;
        do_start; send_byte(DEVW, k); do_stop;
        chk("R5 select acked after write cycle", {31'd0, k}, 32'd1);
        read_burst(16'h0110, 3, q);
        chk("R4 random read returns written bytes", q, 32'h11223300);
    endtask

    task automatic t_page_wrap;
        logic ok;
        logic [31:0] q;
        write_burst(16'h0280, 32'h5A000000, 1, ok); wait_cycle;
        write_burst(16'h027E, 32'hA1A2A300, 3, ok); wait_cycle;
        read_burst(16'h027E, 2, q);
        chk("R6 bytes before page end", q, 32'hA1A20000);
        read_burst(16'h0200, 1, q);
        chk("R6 third byte wrapped to page start", q, 32'hA3000000);
        read_burst(16'h0280, 1, q);
        chk("R6 next page untouched", q, 32'h5A000000);
    endtask

    task automatic t_read_wrap;
        logic ok;
        logic [31:0] q;
        write_burst(16'h07FE, 32'hB1B20000, 2, ok); wait_cycle;
        write_burst(16'h0000, 32'hC1000000, 1, ok); wait_cycle;
        read_burst(16'h07FE, 3, q);
        chk("R7 read wraps at end of array", q, 32'hB1B2C100);
    endtask

    task automatic t_protect;
        logic ok, k;
        logic [31:0] q;
        wp = 1'b1;
        write_burst(16'h0110, 32'h99000000, 1, ok);
        wp = 1'b0;
        do_start; send_byte(DEVW, k); do_stop;
        chk("R8 no write cycle when protected", {31'd0, k}, 32'd1);
        read_burst(16'h0110, 1, q);
        chk("R8 array unchanged when protected", q, 32'h11000000);
    endtask

    task automatic t_nack_release;
        logic ok, k, s;
        logic [7:0] b, extra;
        set_addr(16'h0111, ok);
        do_start;
        send_byte(DEVR, k);
        recv_byte(1'b0, b);
        chk("R9 single read byte", {24'd0, b}, 32'h22);
        oe_seen = 1'b0;
        extra = '0;
        for (int i = 0; i < 9; i++) begin
            clk_bit(1'b1, s);
            if (i < 8) extra = {extra[6:0], s};
        end
        chk("R9 no drive after master nack", {31'd0, oe_seen}, 32'd0);
        chk("R9 line reads idle after nack", {24'd0, extra}, 32'hFF);
        do_stop;
    endtask

    task automatic t_restart_abort;
        logic ok, k;
        logic [31:0] q;
        set_addr(16'h0111, ok);
        send_byte(8'h77, k);
        do_start;
        send_byte(DEVW, k);
        do_stop;
        do_start; send_byte(DEVW, k); do_stop;
        chk("R10 aborted write starts no cycle", {31'd0, k}, 32'd1);
        wait_cycle;
        read_burst(16'h0111, 1, q);
        chk("R10 aborted write stores nothing", q, 32'h22000000);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(3);
        t_reset;
        t_select;
        t_write_read;
        t_page_wrap;
        t_read_wrap;
        t_protect;
        t_nack_release;
        t_restart_abort;
        chk("R11 sda_oe steady while scl high", scl_high_changes, 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule